// File: doc/BRIEF.md
# Windowed Multiply-Accumulate Unit

This block is an unsigned 32 by 32 multiplier that a processor reaches through a small register window. Window register 25 holds a mode byte, and registers 26 and 27 hold the low and high words of the 64-bit result. The two operands come straight from the processor's registers 28 and 29, on the `op_a` and `op_b` inputs. A window transfer is first announced with a start register, a start byte lane and a byte count. It then moves one byte per beat. Each beat advances the lane, and after lane 3 the transfer moves on to lane 0 of the next register.

With the accumulate bit clear, the unit runs free. It samples the operands on every clock edge, publishes their product on the following edge, and keeps its internal accumulator at zero. With the accumulate bit set, the operands are sampled only at the final beat of a write transfer that starts at register 25. On the next edge the product is added to the 64-bit accumulator, and the new sum is written to both the accumulator and the result words. A wrap of that sum sets a carry bit. Writing a one to the carry bit clears it and empties the accumulator.

Top module: `mac_window_unit`

## Requirements
- R1: After synchronous reset the mode byte reads 0x00, the result words read zero while both operands are zero, and `xf_busy` and `xf_reject` are low.
- R2: A start is rejected when its register is below 25, when its byte count is zero, or when register*4 + lane + count exceeds 112. A rejected start pulses `xf_reject` high for the single cycle after it and does not make the unit busy.
- R3: An accepted transfer consumes one byte per cycle in which `bt_valid` is high. Bytes are addressed little-endian within each register: lane n is bits 8n+7..8n. After lane 3 the transfer continues at lane 0 of the next register, and `xf_busy` falls after the last beat.
- R4: With mode bit 0 (bit 0 of register 25) clear, operands are taken every cycle. The unsigned product appears one cycle after sampling, with bits 31:0 in register 26 and bits 63:32 in register 27.
- R5: While mode bit 0 is clear, the accumulator is held at zero. The first accumulation after the mode bit is set therefore yields just that product.
- R6: With mode bit 0 set, the operands are sampled only at the last beat of a write transfer that starts at register 25. Changes on `op_a` and `op_b` at any other time leave the result unchanged.
- R7: In accumulate mode, the cycle after that sampling loads accumulator + product, taken modulo 2^64, into both the accumulator and registers 26 and 27.
- R8: When an accumulation wraps past 2^64, carry (bit 1 of register 25) becomes 1 and stays set until it is cleared.
- R9: Writing a byte with bit 1 set to lane 0 of register 25 clears carry and zeroes the accumulator. An accumulation triggered by the same write then starts from zero.
- R10: Writes to registers 26 and 27, writes to lanes 1 to 3 of register 25, and writes to bits 7:2 of the mode byte are discarded. Those bits always read as zero.
- R11: A start request made while `xf_busy` is high is ignored: it causes neither a rejection nor a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand (processor register 28) |
| op_b | input | 32 | Second operand (processor register 29) |
| xf_start | input | 1 | Announces a window transfer |
| xf_write | input | 1 | 1 = write into the window, 0 = read |
| xf_reg | input | 5 | Start register number |
| xf_lane | input | 2 | Start byte lane |
| xf_len | input | 7 | Byte count |
| bt_valid | input | 1 | One byte moves this cycle |
| bt_wdata | input | 8 | Write byte for the current beat |
| bt_rdata | output | 8 | Byte at the current window position |
| xf_busy | output | 1 | A transfer is in progress |
| xf_reject | output | 1 | Pulse: the previous start was refused |

## Verification
The carry clear and a fresh accumulation can be set off by the same write. A mode byte of 0x03 written while carry is set both clears the flag and arms the accumulator. The bench first drives the accumulator into a wrap so that carry is set. It then writes 0x03 and expects the mode byte to read back 0x01 and the result to equal only the new product, with nothing left of the old sum. A second overlap, a start issued while a read is still in progress, is judged by `xf_reject` staying low and `xf_busy` staying high.

// File: rtl/macw_pkg.sv
package macw_pkg;

    localparam int OPW       = 32;
    localparam int PRODW     = 2 * OPW;
    localparam int LANES     = OPW / 8;
    localparam int LANE_W    = $clog2(LANES);
    localparam int REG_W     = 5;
    localparam int WIN_BASE  = 25;
    localparam int WIN_REGS  = 3;
    localparam int WIN_LIMIT = (WIN_BASE + WIN_REGS) * LANES;
    localparam int BIT_ACC   = 0;
    localparam int BIT_CARRY = 1;

    typedef struct packed {
        logic carry;
        logic acc_en;
    } mode_t;

    typedef struct packed {
        logic [REG_W-1:0]  rnum;
        logic [LANE_W-1:0] lane;
    } wpos_t;

    typedef struct packed {
        logic        vld;
        logic        wr;
        logic        from_mode;
        logic        last;
        wpos_t       pos;
        logic [7:0]  data;
    } beat_t;

    function automatic logic span_ok(input logic [REG_W-1:0] r,
                                     input logic [LANE_W-1:0] l,
                                     input logic [6:0] n,
                                     input int base);
        logic [9:0] stop;
        stop = {r, {LANE_W{1'b0}}} + 10'(l) + 10'(n);
        return (int'(r) >= base) && (n != 7'd0) && (int'(stop) <= WIN_LIMIT);
    endfunction

    function automatic wpos_t step_pos(input wpos_t p);
        wpos_t q;
        if (p.lane == LANE_W'(LANES - 1)) begin
            q.rnum = p.rnum + 1'b1;
            q.lane = '0;
        end else begin
            q.rnum = p.rnum;
            q.lane = p.lane + 1'b1;
        end
        return q;
    endfunction

    function automatic logic [7:0] lane_byte(input logic [OPW-1:0] w,
                                             input logic [LANE_W-1:0] l);
        return w[{l, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/mac_win_seq.sv
module mac_win_seq
    import macw_pkg::*;
#(
    parameter int BASE  = WIN_BASE,
    parameter int LEN_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [REG_W-1:0]  sreg,
    input  logic [LANE_W-1:0] slane,
    input  logic [LEN_W-1:0]  slen,
    input  logic              bt_valid,
    input  logic [7:0]        bt_wdata,
    output logic              busy_o,
    output logic              reject_o,
    output beat_t             beat_o
);

    logic             busy_q;
    logic             reject_q;
    logic             wr_q;
    logic             from_mode_q;
    wpos_t            pos_q;
    logic [LEN_W-1:0] rem_q;
    logic             accept;

    assign accept = span_ok(sreg, slane, 7'(slen), BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            reject_q    <= 1'b0;
            wr_q        <= 1'b0;
            from_mode_q <= 1'b0;
            pos_q       <= '0;
            rem_q       <= '0;
        end else begin
            reject_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    if (accept) begin
                        busy_q      <= 1'b1;
                        wr_q        <= wr;
                        from_mode_q <= (int'(sreg) == BASE);
                        pos_q.rnum  <= sreg;
                        pos_q.lane  <= slane;
                        rem_q       <= slen;
                    end else begin
                        reject_q <= 1'b1;
                    end
                end
            end else if (bt_valid) begin
                pos_q <= step_pos(pos_q);
                rem_q <= rem_q - 1'b1;
                if (rem_q == LEN_W'(1)) busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        beat_o.vld       = busy_q && bt_valid;
        beat_o.wr        = wr_q;
        beat_o.from_mode = from_mode_q;
        beat_o.last      = (rem_q == LEN_W'(1));
        beat_o.pos       = pos_q;
        beat_o.data      = bt_wdata;
    end

    assign busy_o   = busy_q;
    assign reject_o = reject_q;

    // R2
    reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
        reject_q |-> !busy_q);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !reject_q);

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bt_valid && rem_q != LEN_W'(1))
        |=> busy_q && ({pos_q.rnum, pos_q.lane} == $past({pos_q.rnum, pos_q.lane}) + 1'b1));

endmodule

// File: rtl/mac_core.sv
module mac_core
    import macw_pkg::*;
#(
    parameter int BASE = WIN_BASE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    input  beat_t          beat,
    output logic [7:0]     rd_byte
);

    mode_t              mode_q;
    logic [OPW-1:0]     op0_q, op1_q;
    logic [PRODW-1:0]   prod_q, acc_q;
    logic               go_q;

    logic               mode_wr;
    logic               acc_en_nx;
    logic               smp_acc;
    logic               clr_req;
    logic [PRODW-1:0]   mul;
    logic [PRODW:0]     sum;

    always_comb begin
        mode_wr   = beat.vld && beat.wr && (int'(beat.pos.rnum) == BASE)
                    && (beat.pos.lane == '0);
        clr_req   = mode_wr && beat.data[BIT_CARRY];
        acc_en_nx = mode_wr ? beat.data[BIT_ACC] : mode_q.acc_en;
        smp_acc   = beat.vld && beat.wr && beat.last && beat.from_mode && acc_en_nx;
        mul       = {{OPW{1'b0}}, op0_q} * {{OPW{1'b0}}, op1_q};
        sum       = {1'b0, acc_q} + {1'b0, mul};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            op0_q  <= '0;
            op1_q  <= '0;
            prod_q <= '0;
            acc_q  <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= smp_acc;

            if (!mode_q.acc_en || smp_acc) begin
                op0_q <= op_a;
                op1_q <= op_b;
            end

            if (mode_wr) mode_q.acc_en <= beat.data[BIT_ACC];
            if (clr_req)
                mode_q.carry <= 1'b0;
            else if (go_q && sum[PRODW])
                mode_q.carry <= 1'b1;

            if (go_q)
                prod_q <= sum[PRODW-1:0];
            else if (!mode_q.acc_en)
                prod_q <= mul;

            if (go_q)
                acc_q <= sum[PRODW-1:0];
            else if (clr_req || !mode_q.acc_en)
                acc_q <= '0;
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        if (int'(beat.pos.rnum) == BASE) begin
            if (beat.pos.lane == '0) rd_byte = {6'b0, mode_q.carry, mode_q.acc_en};
        end else if (int'(beat.pos.rnum) == BASE + 1) begin
            rd_byte = lane_byte(prod_q[OPW-1:0], beat.pos.lane);
        end else if (int'(beat.pos.rnum) == BASE + 2) begin
            rd_byte = lane_byte(prod_q[PRODW-1:OPW], beat.pos.lane);
        end
    end

    // R5
    acc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.acc_en && !go_q) |=> (acc_q == '0));

    // R6
    hold_ops_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q.acc_en && !smp_acc) |=> ($stable(op0_q) && $stable(op1_q)));

    // R7
    acc_prod_chk: assert property (@(posedge clk) disable iff (rst)
        go_q |=> (prod_q == acc_q));

    // R8
    carry_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q.carry) |-> $past(go_q));

endmodule

// File: rtl/mac_window_unit.sv
module mac_window_unit
    import macw_pkg::*;
#(
    parameter int BASE  = WIN_BASE,
    parameter int LEN_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       op_a,
    input  logic [31:0]       op_b,
    input  logic              xf_start,
    input  logic              xf_write,
    input  logic [4:0]        xf_reg,
    input  logic [1:0]        xf_lane,
    input  logic [6:0]        xf_len,
    input  logic              bt_valid,
    input  logic [7:0]        bt_wdata,
    output logic [7:0]        bt_rdata,
    output logic              xf_busy,
    output logic              xf_reject
);

    beat_t beat;

    mac_win_seq #(.BASE(BASE), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (xf_start),
        .wr       (xf_write),
        .sreg     (xf_reg),
        .slane    (xf_lane),
        .slen     (LEN_W'(xf_len)),
        .bt_valid (bt_valid),
        .bt_wdata (bt_wdata),
        .busy_o   (xf_busy),
        .reject_o (xf_reject),
        .beat_o   (beat)
    );

    mac_core #(.BASE(BASE)) u_core (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .beat    (beat),
        .rd_byte (bt_rdata)
    );

endmodule

// File: tb/test_mac_window_unit.sv
`timescale 1ns/1ps
module test_mac_window_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_a, op_b;
    logic        xf_start, xf_write, bt_valid;
    logic [4:0]  xf_reg;
    logic [1:0]  xf_lane;
    logic [6:0]  xf_len;
    logic [7:0]  bt_wdata, bt_rdata;
    logic        xf_busy, xf_reject;

    int checks = 0;
    int failures = 0;

    logic [63:0] m_acc;
    logic        m_carry, m_mode;
    logic [63:0] m_prod;

    always #10 clk = ~clk;

    mac_window_unit i_mac_window_unit (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .xf_start(xf_start), .xf_write(xf_write), .xf_reg(xf_reg),
        .xf_lane(xf_lane), .xf_len(xf_len), .bt_valid(bt_valid),
        .bt_wdata(bt_wdata), .bt_rdata(bt_rdata),
        .xf_busy(xf_busy), .xf_reject(xf_reject)
    );

    localparam logic [63:0] VEC [6] = '{
        {32'h0000_0000, 32'h1234_5678},
        {32'h0000_0001, 32'hCAFE_F00D},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h0001_0000, 32'h0001_0000},
        {32'h8000_0001, 32'h0000_0003},
        {32'hDEAD_BEEF, 32'h0BAD_F00D}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_xfer(input logic w, input logic [4:0] r,
                              input logic [1:0] l, input logic [6:0] n);
        @(negedge clk);
        xf_start = 1'b1; xf_write = w; xf_reg = r; xf_lane = l; xf_len = n;
        @(negedge clk);
        xf_start = 1'b0;
    endtask

    task automatic win_read(input logic [4:0] r, input logic [1:0] l,
                            input logic [6:0] n, output logic [63:0] v);
        start_xfer(1'b0, r, l, n);
        v = '0;
        for (int i = 0; i < int'(n); i++) begin
            v[i*8 +: 8] = bt_rdata;
            bt_valid = 1'b1;
            @(negedge clk);
        end
        bt_valid = 1'b0;
    endtask

    task automatic win_write(input logic [4:0] r, input logic [1:0] l,
                             input logic [6:0] n, input logic [63:0] d);
        start_xfer(1'b1, r, l, n);
        for (int i = 0; i < int'(n); i++) begin
            bt_wdata = d[i*8 +: 8];
            bt_valid = 1'b1;
            @(negedge clk);
        end
        bt_valid = 1'b0;
    endtask

    task automatic mode_write(input logic [7:0] d);
        logic [64:0] s;
        win_write(5'd25, 2'd0, 7'd1, {56'b0, d});
        if (d[1]) begin m_carry = 1'b0; m_acc = '0; end
        m_mode = d[0];
        if (m_mode) begin
            s = {1'b0, m_acc} + {1'b0, 64'(op_a) * 64'(op_b)};
            if (s[64]) m_carry = 1'b1;
            m_acc  = s[63:0];
            m_prod = s[63:0];
        end
    endtask

    task automatic set_ops(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a; op_b = b;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] v;
        rst = 1'b1; op_a = '0; op_b = '0; xf_start = 0; xf_write = 0;
        xf_reg = '0; xf_lane = '0; xf_len = '0; bt_valid = 0; bt_wdata = '0;
        m_acc = '0; m_carry = 0; m_mode = 0; m_prod = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 busy", 64'(xf_busy), 64'd0);
        chk("R1 reject", 64'(xf_reject), 64'd0);
        win_read(5'd25, 2'd0, 7'd1, v);
        chk("R1 mode byte", v, 64'h0);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R1 product", v, 64'h0);

        // R4 R3 multiply-only vectors across the two result words
        for (int k = 0; k < 6; k++) begin
            set_ops(VEC[k][63:32], VEC[k][31:0]);
            win_read(5'd26, 2'd0, 7'd8, v);
            chk("R4 product", v, 64'(VEC[k][63:32]) * 64'(VEC[k][31:0]));
        end

        // R3 mid-register start crossing into register 27
        win_read(5'd26, 2'd2, 7'd4, v);
        m_prod = 64'(op_a) * 64'(op_b);
        chk("R3 lane wrap", v, {32'b0, m_prod[47:16]});
        chk("R3 busy fall", 64'(xf_busy), 64'd0);

        // R2 rejections and the boundary that fits
        start_xfer(1'b0, 5'd24, 2'd0, 7'd1);
        chk("R2 reg below window", {62'b0, xf_reject, xf_busy}, 64'h2);
        start_xfer(1'b0, 5'd27, 2'd3, 7'd2);
        chk("R2 overrun", {62'b0, xf_reject, xf_busy}, 64'h2);
        start_xfer(1'b0, 5'd26, 2'd0, 7'd0);
        chk("R2 zero length", {62'b0, xf_reject, xf_busy}, 64'h2);
        win_read(5'd27, 2'd3, 7'd1, v);
        chk("R2 exact fit", v, {56'b0, m_prod[63:56]});

        // R10 upper lanes of register 25 discarded
        win_write(5'd25, 2'd1, 7'd3, 64'hFF_FFFF);
        win_read(5'd25, 2'd0, 7'd4, v);
        chk("R10 upper lanes", v, 64'h0);

        // R5 R7 first accumulation after enabling
        set_ops(32'd3, 32'd5);
        mode_write(8'h01);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R5 first accumulate", v, 64'd15);
        win_read(5'd25, 2'd0, 7'd1, v);
        chk("R7 mode byte", v, 64'h01);

        // R6 operands ignored outside the mode write
        set_ops(32'd7, 32'd9);
        repeat (4) @(negedge clk);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R6 hold", v, 64'd15);
        mode_write(8'h01);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R7 second accumulate", v, m_prod);

        // R10 result words are read-only, upper mode bits not stored
        win_write(5'd26, 2'd0, 7'd8, 64'h0123_4567_89AB_CDEF);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R10 result write ignored", v, m_prod);
        mode_write(8'hFD);
        win_read(5'd25, 2'd0, 7'd1, v);
        chk("R10 mode high bits", v, {62'b0, m_carry, m_mode});

        // R8 drive a wrap
        set_ops(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        mode_write(8'h01);
        mode_write(8'h01);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R8 wrapped sum", v, m_prod);
        win_read(5'd25, 2'd0, 7'd1, v);
        chk("R8 carry set", v, 64'h03);
        chk("R8 model wrapped", 64'(m_carry), 64'd1);

        // R9 clear and accumulate in the same write
        set_ops(32'd2, 32'd3);
        mode_write(8'h03);
        win_read(5'd25, 2'd0, 7'd1, v);
        chk("R9 carry cleared", v, 64'h01);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R9 fresh sum", v, 64'd6);

        // R11 start while busy is ignored
        start_xfer(1'b0, 5'd26, 2'd0, 7'd2);
        xf_start = 1'b1; xf_write = 1'b0; xf_reg = 5'd3; xf_lane = 2'd0; xf_len = 7'd1;
        @(negedge clk);
        xf_start = 1'b0;
        chk("R11 no reject", {62'b0, xf_reject, xf_busy}, 64'h1);
        bt_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bt_valid = 1'b0;
        chk("R11 finished", 64'(xf_busy), 64'd0);

        // R5 back to multiply-only, then re-enable from a zero accumulator
        mode_write(8'h00);
        set_ops(32'd10, 32'd20);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R4 free run again", v, 64'd200);
        set_ops(32'd1, 32'd1);
        mode_write(8'h01);
        win_read(5'd26, 2'd0, 7'd8, v);
        chk("R5 acc held zero", v, 64'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule